// File: doc/BRIEF.md
# Synchronous Serial Master with Tick-Aligned Busy Flag

This block is a master-only synchronous serial port. A free-running reload counter produces an internal baud tick once every half bit. Each bit of a frame takes two of these ticks. On the first tick the serial clock leaves its idle level and the data-in line is sampled. On the second tick the clock returns to idle and the next data bit is shifted out. Frames run from 2 to 16 bits and are sent most significant bit first.

The busy flag follows the tick grid, not the buffer write. A word written to the transmit buffer waits for the next baud tick before the frame starts and busy rises, so there can be a delay of up to half a bit. The receive-complete flag is set on the last sampling edge. Busy drops one half bit later, on the final return-to-idle edge, so software that polls receive-complete and then busy sees the same ordering. A write made during a frame is held in the buffer and starts on a tick after the current frame has ended.

Top module: `ssm_master`

## Requirements
- R1: After reset, busy, rx_done, and rx_data are all zero. From the first clock after reset release, sclk equals cfg_cpol.
- R2: The internal tick occurs every cfg_reload+1 clock cycles. During a frame, every sclk transition is exactly cfg_reload+1 cycles after the previous frame event, where the frame start counts as an event.
- R3: busy does not rise in the cycle of the tx_wr write. It rises on the first tick after that write, so it becomes visible between 1 and cfg_reload+1 cycles after the write edge.
- R4: A frame has cfg_len+1 bits, and cfg_len=0 is treated as a 2-bit frame. mosi carries tx_data[n-1] down to tx_data[0]. mosi changes only when sclk returns to idle, and miso is sampled when sclk leaves idle.
- R5: rx_done is set on the last sampling edge of a frame. busy falls exactly cfg_reload+1 cycles later, on the final return of sclk to idle.
- R6: rx_data holds the n received bits right-justified, with the first bit received in the highest position and zeros above bit n-1.
- R7: A pulse on rx_done_clr clears rx_done. rx_done stays clear until the next frame completes, which sets it again. If a completion and a clear happen in the same cycle, the completion wins.
- R8: A tx_wr made while busy is held. After busy falls, it starts a new frame on a later tick without another write. If several writes happen while busy, the last one is the one sent.
- R9: While busy is low, sclk equals cfg_cpol (from the previous cycle) and makes no other transitions. This holds for both polarities.
- R10: Frames of 16 bits with cfg_reload=0 (one tick per cycle) and frames of 2 bits are sent and received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_reload | input | RW | Half-bit period minus one, in clock cycles |
| cfg_len | input | $clog2(W) | Frame length minus one |
| cfg_cpol | input | 1 | Idle level of sclk |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | W | Transmit word, right-justified |
| rx_done_clr | input | 1 | Clears the receive-complete flag |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| rx_done | output | 1 | Receive-complete request flag |
| rx_data | output | W | Last received word, right-justified |

## Verification
The assertions assume that cfg_len, cfg_reload and cfg_cpol stay constant while busy is high. They also assume that miso is stable at each sampling tick. The bench changes configuration only while the port is idle. Its slave model drives miso a couple of nanoseconds after the clock edge that returned sclk to idle, so each new bit is settled well before the next tick samples it.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic [1:0] {
        EV_NONE,
        EV_LOAD,
        EV_LATCH,
        EV_SHIFT
    } ssm_evt_e;
endpackage

// File: rtl/ssm_baud.sv
module ssm_baud #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    typedef struct packed {
        logic [RW-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;

    assign tick = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) st_d.cnt = reload;
        else                st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssm_engine.sv
module ssm_engine
    import ssm_pkg::*;
#(
    parameter int W  = 16,
    localparam int LW = $clog2(W),
    localparam int CW = $clog2(2 * W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_cpol,
    input  logic          tx_wr,
    input  logic [W-1:0]  tx_data,
    input  logic          rx_done_clr,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          rx_done,
    output logic [W-1:0]  rx_data
);
    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic          pend;
        logic          done;
        logic [W-1:0]  txb;
        logic [W-1:0]  sh;
        logic [W-1:0]  rsh;
        logic [W-1:0]  rx;
        logic [CW-1:0] cnt;
    } eng_st_t;

    eng_st_t     st_d, st_q;
    ssm_evt_e    ev;
    logic [CW-1:0] nbits;
    logic [CW-1:0] last;

    always_comb begin
        nbits = CW'(cfg_len) + 1'b1;
        if (cfg_len == '0) nbits = CW'(2);
        last = (nbits << 1) - 1'b1;

        ev = EV_NONE;
        if (tick) begin
            if (!st_q.busy)        ev = st_q.pend ? EV_LOAD : EV_NONE;
            else if (!st_q.cnt[0]) ev = EV_LATCH;
            else                   ev = EV_SHIFT;
        end

        st_d = st_q;
        if (tx_wr) begin
            st_d.txb  = tx_data;
            st_d.pend = 1'b1;
        end
        if (rx_done_clr) st_d.done = 1'b0;
        if (!st_q.busy)  st_d.sclk = cfg_cpol;

        case (ev)
            EV_LOAD: begin
                st_d.busy = 1'b1;
                st_d.pend = tx_wr;
                st_d.sh   = st_q.txb << (CW'(W) - nbits);
                st_d.rsh  = '0;
                st_d.cnt  = '0;
            end
            EV_LATCH: begin
                st_d.sclk = ~cfg_cpol;
                st_d.rsh  = {st_q.rsh[W-2:0], miso};
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == last - 1'b1) begin
                    st_d.rx   = {st_q.rsh[W-2:0], miso};
                    st_d.done = 1'b1;
                end
            end
            EV_SHIFT: begin
                st_d.sclk = cfg_cpol;
                st_d.sh   = st_q.sh << 1;
                if (st_q.cnt == last) st_d.busy = 1'b0;
                else                  st_d.cnt  = st_q.cnt + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk    = st_q.sclk;
    assign mosi    = st_q.sh[W-1];
    assign busy    = st_q.busy;
    assign rx_done = st_q.done;
    assign rx_data = st_q.rx;

    AST_BUSY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(tick)); // R3
    AST_BUSY_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(tick) && !$past(rx_done_clr && !st_q.done) && ($past(st_q.sclk) != $past(cfg_cpol))); // R5
    AST_DONE_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(tick) && $past(st_q.busy)); // R5
    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !st_q.busy |-> st_q.sclk == $past(cfg_cpol)); // R9
    AST_SCLK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.busy) && !$stable(st_q.sclk) |-> $past(tick)); // R2
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && st_q.busy |=> st_q.pend); // R8
endmodule

// File: rtl/ssm_master.sv
module ssm_master #(
    parameter int W  = 16,
    parameter int RW = 16,
    localparam int LW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] cfg_reload,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_cpol,
    input  logic          tx_wr,
    input  logic [W-1:0]  tx_data,
    input  logic          rx_done_clr,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          rx_done,
    output logic [W-1:0]  rx_data
);
    logic tick;

    ssm_baud #(.RW(RW)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (cfg_reload),
        .tick   (tick)
    );

    ssm_engine #(.W(W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cfg_len     (cfg_len),
        .cfg_cpol    (cfg_cpol),
        .tx_wr       (tx_wr),
        .tx_data     (tx_data),
        .rx_done_clr (rx_done_clr),
        .miso        (miso),
        .sclk        (sclk),
        .mosi        (mosi),
        .busy        (busy),
        .rx_done     (rx_done),
        .rx_data     (rx_data)
    );
endmodule

// File: tb/tb_ssm_master.sv
`timescale 1ns/1ps
module tb_ssm_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_reload = '0;
    logic [3:0]  cfg_len = 4'd7;
    logic        cfg_cpol = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic        rx_done_clr = 1'b0;
    logic        miso = 1'b0;
    logic        sclk, mosi, busy, rx_done;
    logic [15:0] rx_data;

    int checks = 0;
    int errors = 0;

    ssm_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload), .cfg_len(cfg_len),
        .cfg_cpol(cfg_cpol), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_done_clr(rx_done_clr), .miso(miso), .sclk(sclk), .mosi(mosi),
        .busy(busy), .rx_done(rx_done), .rx_data(rx_data)
    );

    always #5 clk = ~clk;

    // slave model and timing monitor, 2 ns after each rising edge
    logic [15:0] slave_word = '0;
    logic [15:0] cap = '0;
    int  nbits_m = 8;
    int  sidx = 0;
    int  nlatch = 0;
    int  cyc = 0;
    int  last_evt = 0;
    int  gap_err = 0;
    int  done_cyc = 0;
    int  fall_cyc = 0;
    logic busy_p = 1'b0, sclk_p = 1'b0, done_p = 1'b0;

    always @(posedge clk) begin
        #2;
        cyc++;
        if (busy && !busy_p) begin
            sidx = nbits_m - 1;
            miso = slave_word[sidx];
            cap = '0;
            nlatch = 0;
            last_evt = cyc;
        end else if (busy && sclk != sclk_p) begin
            if (cyc - last_evt != int'(cfg_reload) + 1) gap_err++;
            last_evt = cyc;
            if (sclk != cfg_cpol) begin
                cap = {cap[14:0], mosi};
                nlatch++;
            end else if (sidx > 0) begin
                sidx--;
                miso = slave_word[sidx];
            end
        end
        if (rx_done && !done_p) done_cyc = cyc;
        if (!busy && busy_p) begin
            fall_cyc = cyc;
            if (cyc - last_evt != int'(cfg_reload) + 1) gap_err++;
        end
        busy_p = busy;
        sclk_p = sclk;
        done_p = rx_done;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nb_of(input logic [3:0] l);
        return (l == 0) ? 2 : int'(l) + 1;
    endfunction

    task automatic write_word(input logic [15:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // one full frame; checks R2 R3 R4 R5 R6
    task automatic run_frame(input logic [15:0] d, input logic [15:0] sw, input string tag);
        int n, dly;
        logic [15:0] mask;
        n = nb_of(cfg_len);
        nbits_m = n;
        slave_word = sw;
        mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
        gap_err = 0;
        @(negedge clk);
        rx_done_clr = 1'b1;
        @(negedge clk);
        rx_done_clr = 1'b0;
        write_word(d);
        chk(busy == 1'b0, "R3", {tag, " busy at write"}, int'(busy), 0);
        dly = 0;
        while (!busy) begin
            @(negedge clk);
            dly++;
        end
        chk(dly >= 1 && dly <= int'(cfg_reload) + 1, "R3", {tag, " busy delay"}, dly, int'(cfg_reload) + 1);
        while (busy) @(negedge clk);
        chk(cap == (d & mask), "R4", {tag, " mosi bits"}, int'(cap), int'(d & mask));
        chk(nlatch == n, "R4", {tag, " edge count"}, nlatch, n);
        chk(rx_data == (sw & mask), "R6", {tag, " rx_data"}, int'(rx_data), int'(sw & mask));
        chk(gap_err == 0, "R2", {tag, " sclk spacing"}, gap_err, 0);
        chk(rx_done == 1'b1 && fall_cyc - done_cyc == int'(cfg_reload) + 1, "R5",
            {tag, " done-to-idle"}, fall_cyc - done_cyc, int'(cfg_reload) + 1);
        chk(sclk == cfg_cpol, "R9", {tag, " sclk idle after"}, int'(sclk), int'(cfg_cpol));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(busy == 0 && rx_done == 0, "R1", "flags after reset", {busy, rx_done}, 0);
        chk(rx_data == 0, "R1", "rx_data after reset", int'(rx_data), 0);
        chk(sclk == cfg_cpol, "R1", "sclk after reset", int'(sclk), int'(cfg_cpol));
    endtask

    task automatic t_basic();
        cfg_reload = 16'd3; cfg_len = 4'd7; cfg_cpol = 1'b0;
        run_frame(16'h00A5, 16'h003C, "basic8");
        run_frame(16'h005A, 16'h00C3, "basic8b");
    endtask

    task automatic t_long_fast();
        cfg_reload = 16'd0; cfg_len = 4'd15; cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(16'hB38E, 16'h71D4, "R10 len16");
    endtask

    task automatic t_short();
        cfg_reload = 16'd2; cfg_cpol = 1'b0; cfg_len = 4'd1;
        repeat (2) @(negedge clk);
        run_frame(16'h0002, 16'h0001, "R10 len2");
        cfg_len = 4'd0;
        run_frame(16'h0001, 16'h0002, "R4 len0");
        cfg_reload = 16'd7; cfg_len = 4'd4;
        run_frame(16'h0013, 16'h000C, "slow5");
    endtask

    task automatic t_clear();
        @(negedge clk);
        rx_done_clr = 1'b1;
        @(negedge clk);
        rx_done_clr = 1'b0;
        chk(rx_done == 1'b0, "R7", "clear", int'(rx_done), 0);
        repeat (5) @(negedge clk);
        chk(rx_done == 1'b0, "R7", "stays clear", int'(rx_done), 0);
    endtask

    task automatic t_held();
        logic [15:0] first;
        cfg_reload = 16'd2; cfg_len = 4'd7; cfg_cpol = 1'b0;
        first = 16'h0081;
        nbits_m = 8;
        slave_word = 16'h00FF;
        write_word(first);
        while (!busy) @(negedge clk);
        write_word(16'h0011);
        write_word(16'h0066);
        while (busy) @(negedge clk);
        chk(cap == first, "R8", "first frame", int'(cap), int'(first));
        repeat (int'(cfg_reload) + 3) @(negedge clk);
        chk(busy == 1'b1, "R8", "held word started", int'(busy), 1);
        while (busy) @(negedge clk);
        chk(cap == 16'h0066, "R8", "last write sent", int'(cap), 16'h0066);
        repeat (3 * (int'(cfg_reload) + 1)) @(negedge clk);
        chk(busy == 1'b0, "R8", "no extra frame", int'(busy), 0);
    endtask

    task automatic t_idle_level();
        int bad;
        bad = 0;
        cfg_cpol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (sclk != 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9", "idle high", bad, 0);
        cfg_cpol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (sclk != 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9", "idle low", bad, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clear();
        t_long_fast();
        t_short();
        t_held();
        t_idle_level();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule